// File: doc/BRIEF.md
# Audio Sample Fetch DMA

This block moves audio samples from system memory into a local sample FIFO. Software uses a byte-wide register port to program a start byte address and an inclusive stop byte address, then issues a start command. The engine walks the region in ascending word order. It issues read bursts on a request/acknowledge memory port and pushes every returned 32-bit word into the FIFO. A downstream consumer drains the FIFO through a valid/ready sample port. On that port a word leaves only in a cycle where both valid and ready are high. The consumer may hold ready low for any length of time, and the FIFO then fills until fetching pauses. The memory return path has no ready. The engine requests a burst only when the whole burst fits in the FIFO, so every returned beat is accepted.

Six interrupt causes are gathered in a write-one-to-clear status register. A cause drives the single interrupt line only if two separate gates let it through: its bit in the mute register and its bit in the DMA mask register. Fetching is paced by a fill threshold and can be cut short by a halt command. The FIFO can be flushed through a self-clearing control bit.

Register offsets (5-bit address): 0x00 control, 0x01 start command, 0x02 halt command, 0x03 fill threshold, 0x04–0x07 start address bytes, 0x08–0x0B stop address bytes, 0x0C DMA mask, 0x0D status, 0x0E mute.

Top module: `audio_fetch_dma`

## Requirements
- R1: The start address is written through offsets 0x04..0x07 and the stop address through 0x08..0x0B. Each address is 32 bits, one byte per offset, least significant byte at the lowest offset. Every byte reads back as written.
- R2: Writing 1 to bit 0 at offset 0x01 while idle starts a transfer. Request addresses begin at the start address with bits 1:0 ignored and rise contiguously. The words leave the sample port in address order. A request holds its address and length until it is acknowledged.
- R3: The transfer covers every word from the start word to the stop word inclusive. Control bits 2:1 set the burst length (0 gives 4 beats, 1 gives 8, 2 or 3 give 16), and control bit 0 enables bursts (when it is 0, every request is 1 beat). The last request is shortened so that it ends exactly at the stop word.
- R4: A new request is made only when no burst is outstanding, the FIFO count is below the threshold at offset 0x03, and the FIFO has room for the whole burst. A threshold of 0 stops all fetching.
- R5: Once the final word has been delivered, status bit 2 (done) sets and no further request is made.
- R6: Writing 1 to bit 0 at offset 0x02 ends the transfer. No further request follows, and done does not set.
- R7: Status bits are bit 5 error, bit 4 lost, bit 3 retry, bit 2 done, bit 1 full and bit 0 empty. Writing 1 to a bit clears it and bits written with 0 keep their value.
- R8: The interrupt line is high when some status bit is set whose mute bit (same layout) is 0 and whose mask bit is 0. Mask bit 7 gates done, and mask bits 5, 4, 3, 1 and 0 gate the cause with the same index.
- R9: Retry sets when a start command arrives during a transfer. Lost sets when a data beat arrives with no burst outstanding. Error sets when a beat returns with its error flag high.
- R10: Full sets when the FIFO holds its full depth of words. Empty sets when the consumer is ready while the FIFO is empty and a transfer is running, but not while idle.
- R11: Writing control with bit 7 set empties the FIFO. Bit 7 reads back as 0 and bits 3:0 take the written value.
- R12: The lock output equals control bit 3 while a request is pending and is 0 otherwise.
- R13: After reset the status is 0x00, mute is 0x3F, mask is 0xFF, the threshold is 128, and the interrupt line, memory request and sample valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Burst read request, held until acknowledged |
| mem_addr | output | 32 | Byte address of the first beat |
| mem_len | output | 5 | Beats in the burst (1 to 16) |
| mem_lock | output | 1 | Locked-transfer qualifier for the request |
| mem_ack | input | 1 | Memory accepts the pending request |
| mem_rvalid | input | 1 | Returned data beat valid |
| mem_rdata | input | 32 | Returned data word |
| mem_rerr | input | 1 | Error flag for the returned beat |
| smp_valid | output | 1 | Sample word available |
| smp_ready | input | 1 | Consumer takes the sample word |
| smp_data | output | 32 | Sample word |
| irq | output | 1 | Interrupt line |

## Verification
If the remaining-word count or the word pointer is wrong, it appears at the memory port in the first request that uses it, as a bad address or a burst length that does not match the shortened final length. If the FIFO pointers slip, the next word popped on the sample port is wrong. A lost or extra word also changes the total word count, which the done check compares. A fault in the interrupt gating shows on the irq pin in the same cycle as the register write that exposes it.

// File: rtl/afd_pkg.sv
package afd_pkg;
  localparam int REG_AW = 5;
  localparam int NCAUSE = 6;

  localparam logic [REG_AW-1:0] OFS_CTRL  = 5'h00;
  localparam logic [REG_AW-1:0] OFS_GO    = 5'h01;
  localparam logic [REG_AW-1:0] OFS_HALT  = 5'h02;
  localparam logic [REG_AW-1:0] OFS_THR   = 5'h03;
  localparam logic [REG_AW-1:0] OFS_BEGIN = 5'h04;
  localparam logic [REG_AW-1:0] OFS_END   = 5'h08;
  localparam logic [REG_AW-1:0] OFS_MASK  = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_STS   = 5'h0D;
  localparam logic [REG_AW-1:0] OFS_MUTE  = 5'h0E;

  // cause indices inside the status and mute registers
  localparam int C_EMPTY = 0;
  localparam int C_FULL  = 1;
  localparam int C_DONE  = 2;
  localparam int C_RETRY = 3;
  localparam int C_LOST  = 4;
  localparam int C_ERR   = 5;

  // mask register position of the done gate
  localparam int MASK_DONE_BIT = 7;

  typedef struct packed {
    logic       lock;
    logic [1:0] bsel;
    logic       ben;
  } ctrl_t;
endpackage

// File: rtl/afd_fifo.sv
module afd_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic          valid,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full
);
  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign valid   = (cnt_q != '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && valid;
  assign head    = store[rp_q];
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (do_push) store[wp_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + AW'(1);
      if (do_pop)  rp_q <= rp_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/afd_regs.sv
module afd_regs
  import afd_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int NB    = ADDR_W / 8,
  localparam int WA    = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [NCAUSE-1:0] cause_set,
  output ctrl_t             ctrl,
  output logic [7:0]        thresh,
  output logic [WA-1:0]     start_word,
  output logic [WA-1:0]     stop_word,
  output logic              go_p,
  output logic              halt_p,
  output logic              fifo_clr,
  output logic [NCAUSE-1:0] sts,
  output logic [NCAUSE-1:0] mute,
  output logic              irq
);
  ctrl_t             ctrl_q;
  logic [7:0]        thr_q, mask_q;
  logic [NCAUSE-1:0] sts_q, mute_q, w1c, gate;
  logic [7:0]        sa_b [NB];
  logic [7:0]        ea_b [NB];
  logic [ADDR_W-1:0] sa_v, ea_v;

  function automatic logic hit(input logic [REG_AW-1:0] a);
    return reg_wen && (reg_addr == a);
  endfunction

  assign go_p     = hit(OFS_GO) && reg_wdata[0];
  assign halt_p   = hit(OFS_HALT) && reg_wdata[0];
  assign fifo_clr = hit(OFS_CTRL) && reg_wdata[7];
  assign w1c      = hit(OFS_STS) ? reg_wdata[NCAUSE-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      thr_q  <= 8'd128;
      mask_q <= 8'hFF;
      mute_q <= '1;
      sts_q  <= '0;
      for (int b = 0; b < NB; b++) begin
        sa_b[b] <= '0;
        ea_b[b] <= '0;
      end
    end else begin
      if (hit(OFS_CTRL)) ctrl_q <= ctrl_t'(reg_wdata[3:0]);
      if (hit(OFS_THR))  thr_q  <= reg_wdata;
      if (hit(OFS_MASK)) mask_q <= reg_wdata;
      if (hit(OFS_MUTE)) mute_q <= reg_wdata[NCAUSE-1:0];
      for (int b = 0; b < NB; b++) begin
        if (hit(OFS_BEGIN + REG_AW'(b))) sa_b[b] <= reg_wdata;
        if (hit(OFS_END + REG_AW'(b)))   ea_b[b] <= reg_wdata;
      end
      // a new event wins over a clear in the same cycle
      sts_q <= (sts_q & ~w1c) | cause_set;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_addr
    assign sa_v[8*b +: 8] = sa_b[b];
    assign ea_v[8*b +: 8] = ea_b[b];
  end

  assign start_word = sa_v[ADDR_W-1:2];
  assign stop_word  = ea_v[ADDR_W-1:2];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL: reg_rdata = {4'b0, ctrl_q};
      OFS_THR:  reg_rdata = thr_q;
      OFS_MASK: reg_rdata = mask_q;
      OFS_STS:  reg_rdata = 8'(sts_q);
      OFS_MUTE: reg_rdata = 8'(mute_q);
      default:  reg_rdata = '0;
    endcase
    for (int b = 0; b < NB; b++) begin
      if (reg_addr == OFS_BEGIN + REG_AW'(b)) reg_rdata = sa_b[b];
      if (reg_addr == OFS_END + REG_AW'(b))   reg_rdata = ea_b[b];
    end
  end

  // mask gate per cause: done sits at the high mask bit
  always_comb begin
    gate = mask_q[NCAUSE-1:0];
    gate[C_DONE] = mask_q[MASK_DONE_BIT];
  end

  assign irq    = |(sts_q & ~mute_q & ~gate);
  assign ctrl   = ctrl_q;
  assign thresh = thr_q;
  assign sts    = sts_q;
  assign mute   = mute_q;
  // sa_v/ea_v low bits only feed readback through the byte arrays
endmodule

// File: rtl/afd_fetch.sv
module afd_fetch #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 256,
  parameter int CNT_W  = 9,
  parameter int LEN_W  = 5,
  localparam int WA    = ADDR_W - 2,
  localparam int RW    = WA + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_p,
  input  logic              halt_p,
  input  logic [WA-1:0]     start_word,
  input  logic [WA-1:0]     stop_word,
  input  logic              burst_en,
  input  logic [1:0]        burst_sel,
  input  logic              lock_en,
  input  logic [7:0]        thresh,
  input  logic [CNT_W-1:0]  fifo_count,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LEN_W-1:0]  mem_len,
  output logic              mem_lock,
  input  logic              mem_ack,
  input  logic              mem_rvalid,
  input  logic              mem_rerr,
  output logic              push,
  output logic              running,
  output logic              ev_done,
  output logic              ev_retry,
  output logic              ev_lost,
  output logic              ev_err
);
  logic             run_q, req_q;
  logic [WA-1:0]    cur_q;
  logic [RW-1:0]    rem_q;
  logic [LEN_W-1:0] out_q, len_q, blen, take;
  logic             below, room, issue, beat;

  always_comb begin
    if (!burst_en) blen = LEN_W'(1);
    else begin
      case (burst_sel)
        2'd0:    blen = LEN_W'(4);
        2'd1:    blen = LEN_W'(8);
        default: blen = LEN_W'(16);
      endcase
    end
  end

  // shorten the last burst so it stops on the final word
  assign take  = (rem_q < RW'(blen)) ? rem_q[LEN_W-1:0] : blen;
  assign below = 32'(fifo_count) < 32'(thresh);
  assign room  = (32'(DEPTH) - 32'(fifo_count)) >= 32'(take);
  assign issue = run_q && !req_q && (out_q == '0) && (rem_q != '0)
                 && below && room && !halt_p;
  assign beat  = mem_rvalid && (out_q != '0);

  assign ev_done  = beat && (out_q == LEN_W'(1)) && (rem_q == '0) && run_q && !req_q;
  assign ev_retry = go_p && run_q;
  assign ev_lost  = mem_rvalid && (out_q == '0);
  assign ev_err   = beat && mem_rerr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      req_q <= 1'b0;
      cur_q <= '0;
      rem_q <= '0;
      out_q <= '0;
      len_q <= '0;
    end else begin
      if (beat) out_q <= out_q - LEN_W'(1);
      if (halt_p) begin
        run_q <= 1'b0;
        req_q <= 1'b0;
      end else if (go_p && !run_q) begin
        run_q <= 1'b1;
        cur_q <= start_word;
        rem_q <= RW'(stop_word) - RW'(start_word) + RW'(1);
      end else begin
        if (req_q && mem_ack) begin
          req_q <= 1'b0;
          out_q <= len_q;
          cur_q <= cur_q + WA'(len_q);
          rem_q <= rem_q - RW'(len_q);
        end else if (issue) begin
          req_q <= 1'b1;
          len_q <= take;
        end
        if (ev_done) run_q <= 1'b0;
      end
    end
  end

  assign mem_req  = req_q;
  assign mem_addr = {cur_q, 2'b00};
  assign mem_len  = len_q;
  assign mem_lock = req_q && lock_en;
  assign push     = beat;
  assign running  = run_q;
endmodule

// File: rtl/audio_fetch_dma.sv
module audio_fetch_dma
  import afd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [4:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LEN_W-1:0]  mem_len,
  output logic              mem_lock,
  input  logic              mem_ack,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rerr,
  output logic              smp_valid,
  input  logic              smp_ready,
  output logic [DATA_W-1:0] smp_data,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH) + 1;
  localparam int WA    = ADDR_W - 2;

  ctrl_t             ctrl;
  logic [7:0]        thresh;
  logic [WA-1:0]     start_word, stop_word;
  logic              go_p, halt_p, fifo_clr;
  logic [NCAUSE-1:0] sts, mute, cause_set;
  logic [CNT_W-1:0]  fifo_count;
  logic              fifo_full, push, running;
  logic              ev_done, ev_retry, ev_lost, ev_err;

  afd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk, .rst_n, .reg_wen, .reg_addr, .reg_wdata, .reg_rdata,
    .cause_set, .ctrl, .thresh, .start_word, .stop_word,
    .go_p, .halt_p, .fifo_clr, .sts, .mute, .irq
  );

  afd_fetch #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_fetch (
    .clk, .rst_n, .go_p, .halt_p, .start_word, .stop_word,
    .burst_en(ctrl.ben), .burst_sel(ctrl.bsel), .lock_en(ctrl.lock),
    .thresh, .fifo_count, .mem_req, .mem_addr, .mem_len, .mem_lock,
    .mem_ack, .mem_rvalid, .mem_rerr, .push, .running,
    .ev_done, .ev_retry, .ev_lost, .ev_err
  );

  afd_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk, .rst_n, .clr(fifo_clr), .push, .push_data(mem_rdata),
    .pop(smp_ready), .valid(smp_valid), .head(smp_data),
    .count(fifo_count), .full(fifo_full)
  );

  always_comb begin
    cause_set          = '0;
    cause_set[C_EMPTY] = smp_ready && !smp_valid && running;
    cause_set[C_FULL]  = fifo_full;
    cause_set[C_DONE]  = ev_done;
    cause_set[C_RETRY] = ev_retry;
    cause_set[C_LOST]  = ev_lost;
    cause_set[C_ERR]   = ev_err;
  end
endmodule

// File: rtl/afd_checker.sv
module afd_checker #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 256,
  parameter int CNT_W  = 9,
  parameter int LEN_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LEN_W-1:0]  mem_len,
  input logic              mem_lock,
  input logic              halt_p,
  input logic [CNT_W-1:0]  fifo_count,
  input logic [7:0]        thresh,
  input logic [5:0]        sts,
  input logic [5:0]        mute,
  input logic              irq
);
  p_req_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !halt_p) |=> (mem_req && $stable(mem_addr) && $stable(mem_len)));

  p_len_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_len != '0 && 32'(mem_len) <= 16));

  p_below_thresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> (32'($past(fifo_count)) < 32'($past(thresh))));

  p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[2]) |-> !mem_req);

  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(sts & ~mute));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fifo_count) <= DEPTH);

  p_lock_in_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lock |-> mem_req);
endmodule

bind audio_fetch_dma afd_checker #(
  .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_len(mem_len), .mem_lock(mem_lock),
  .halt_p(halt_p), .fifo_count(fifo_count), .thresh(thresh),
  .sts(sts), .mute(mute), .irq(irq)
);

// File: tb/sim_audio_fetch_dma.sv
`timescale 1ns/1ps
module sim_audio_fetch_dma;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        reg_wen = 0;
  logic [4:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic        mem_req, mem_lock;
  logic [31:0] mem_addr;
  logic [4:0]  mem_len;
  logic        mem_ack = 0, mem_rvalid = 0, mem_rerr = 0;
  logic [31:0] mem_rdata = 0;
  logic        smp_valid, smp_ready = 0;
  logic [31:0] smp_data;
  logic        irq;

  audio_fetch_dma #(.DEPTH(32)) u0 (
    .clk, .rst_n, .reg_wen, .reg_addr, .reg_wdata, .reg_rdata,
    .mem_req, .mem_addr, .mem_len, .mem_lock, .mem_ack, .mem_rvalid,
    .mem_rdata, .mem_rerr, .smp_valid, .smp_ready, .smp_data, .irq
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_addr, rd_addr;
  int  exp_rem, exp_blen, popped, req_words;
  bit  exp_lock, chk_req, chk_data, cons_en, inject_err, inject_lost;
  logic [7:0] r;

  function automatic logic [31:0] memword(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A17C3E5;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_wen = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wen = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  // memory model: acknowledges requests, returns beats with random gaps
  initial begin
    forever begin
      @(negedge clk);
      mem_ack = 0; mem_rvalid = 0; mem_rerr = 0;
      if (inject_lost && !mem_req) begin
        mem_rvalid = 1; mem_rdata = 32'hDEAD0000; inject_lost = 0;
      end else if (mem_req) begin
        repeat ($urandom % 3) @(negedge clk);
        if (mem_req) begin
          logic [31:0] a;
          int n;
          a = mem_addr; n = int'(mem_len);
          if (chk_req) begin
            int e;
            e = (exp_blen < exp_rem) ? exp_blen : exp_rem;
            chk(a == exp_addr, "R2 request address", a, exp_addr);
            chk(n == e, "R3 burst length", n, e);
            chk(mem_lock == exp_lock, "R12 lock", mem_lock, exp_lock);
            exp_addr = exp_addr + 32'(4 * n);
            exp_rem  = exp_rem - n;
          end
          req_words += n;
          mem_ack = 1;
          @(negedge clk); mem_ack = 0;
          for (int i = 0; i < n; i++) begin
            repeat ($urandom % 2) @(negedge clk);
            mem_rvalid = 1; mem_rdata = memword(a + 32'(4 * i));
            mem_rerr = inject_err; inject_err = 0;
            @(negedge clk); mem_rvalid = 0; mem_rerr = 0;
          end
        end
      end
    end
  end

  // consumer: random ready, checks word order
  initial begin
    forever begin
      @(negedge clk);
      smp_ready = cons_en && (($urandom % 4) != 0);
      if (smp_valid && smp_ready) begin
        if (chk_data) chk(smp_data == memword(rd_addr), "R2 sample order", smp_data, memword(rd_addr));
        rd_addr += 4;
        popped++;
      end
    end
  end

  task automatic setup(input logic [31:0] sa, input int nw, input bit ben,
                       input logic [1:0] bsel, input logic [7:0] thr, input bit lk);
    logic [31:0] ea;
    ea = sa + 32'(4 * nw) - 1;
    wr(5'h00, {4'b0, lk, bsel, ben});
    wr(5'h03, thr);
    for (int b = 0; b < 4; b++) wr(5'(4 + b), sa[8*b +: 8]);
    for (int b = 0; b < 4; b++) wr(5'(8 + b), ea[8*b +: 8]);
    wr(5'h0D, 8'h3F);
    exp_addr = {sa[31:2], 2'b00}; rd_addr = exp_addr; exp_rem = nw;
    exp_blen = ben ? (4 << ((bsel == 2'd3) ? 2 : bsel)) : 1;
    exp_lock = lk; popped = 0; req_words = 0; chk_req = 1; chk_data = 1;
  endtask

  task automatic finish_xfer(input int nw, output logic [7:0] st);
    for (int c = 0; c < 5000 && popped < nw; c++) @(negedge clk);
    repeat (3) @(negedge clk);
    rd(5'h0D, st);
    chk(st[2] == 1'b1, "R5 done set", st, 8'h04);
    chk(popped == nw, "R2 words delivered", popped, nw);
    chk(req_words == nw, "R3 inclusive word count", req_words, nw);
    begin
      bit quiet;
      quiet = 1;
      for (int c = 0; c < 20; c++) begin @(negedge clk); if (mem_req) quiet = 0; end
      chk(quiet, "R5 idle after done", !quiet, 0);
    end
  endtask

  task automatic run_xfer(input logic [31:0] sa, input int nw, input bit ben,
                          input logic [1:0] bsel, input logic [7:0] thr, input bit lk,
                          output logic [7:0] st);
    setup(sa, nw, ben, bsel, thr, lk);
    cons_en = 1;
    wr(5'h01, 8'h01);
    finish_xfer(nw, st);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] st;
    void'($urandom(32'd2024));
    cons_en = 0; chk_req = 0; chk_data = 0; inject_err = 0; inject_lost = 0;
    popped = 0; req_words = 0;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(irq == 0 && mem_req == 0 && smp_valid == 0, "R13 outputs low", {irq, mem_req, smp_valid}, 0);
    rd(5'h0D, r); chk(r == 8'h00, "R13 status", r, 8'h00);
    rd(5'h0E, r); chk(r == 8'h3F, "R13 mute", r, 8'h3F);
    rd(5'h0C, r); chk(r == 8'hFF, "R13 mask", r, 8'hFF);
    rd(5'h03, r); chk(r == 8'd128, "R13 threshold", r, 128);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 byte access
    wr(5'h04, 8'h12); wr(5'h05, 8'h34); wr(5'h06, 8'h56); wr(5'h07, 8'h78);
    rd(5'h04, r); chk(r == 8'h12, "R1 byte0", r, 8'h12);
    rd(5'h07, r); chk(r == 8'h78, "R1 byte3", r, 8'h78);
    wr(5'h0B, 8'h9A); rd(5'h0B, r); chk(r == 8'h9A, "R1 stop byte3", r, 8'h9A);

    // R1/R2/R3 directed: 10 words, 4-beat bursts -> 4,4,2 (start checked via request address)
    run_xfer(32'h00AB_C100, 10, 1, 2'd0, 8'd16, 0, st);

    // R8 gating with done pending
    wr(5'h0C, 8'h7F); wr(5'h0E, 8'h3B);
    @(negedge clk); chk(irq == 1, "R8 done unmuted unmasked", irq, 1);
    wr(5'h0E, 8'h3F);
    @(negedge clk); chk(irq == 0, "R8 muted", irq, 0);
    wr(5'h0E, 8'h3B); wr(5'h0C, 8'hFF);
    @(negedge clk); chk(irq == 0, "R8 masked by bit7", irq, 0);
    wr(5'h0C, 8'h7F);
    // R7 write-one-to-clear of done only
    wr(5'h0D, 8'h04);
    @(negedge clk); chk(irq == 0, "R7 irq after clear", irq, 0);
    rd(5'h0D, r); chk(r[2] == 0, "R7 done cleared", r, 0);

    // R4 threshold pacing: 8-word threshold, consumer stalled
    setup(32'h0000_2000, 40, 1, 2'd0, 8'd8, 0);
    cons_en = 0;
    wr(5'h01, 8'h01);
    repeat (100) @(negedge clk);
    chk(req_words == 8, "R4 stops at threshold", req_words, 8);
    cons_en = 1;
    finish_xfer(40, st);

    // R9 error beat
    inject_err = 1;
    run_xfer(32'h0000_5000, 6, 1, 2'd1, 8'd16, 0, st);
    chk(st[5] == 1, "R9 error cause", st, 8'h20);
    // R8 error gate via mask bit5
    wr(5'h0E, 8'h1F); wr(5'h0C, 8'hDF);
    @(negedge clk); chk(irq == 1, "R8 error unmasked", irq, 1);
    wr(5'h0D, 8'h04);
    rd(5'h0D, r); chk(r[5] == 1, "R7 unwritten bit kept", r, 8'h20);
    wr(5'h0D, 8'h3F);
    rd(5'h0D, r); chk(r == 8'h00, "R7 clear all", r, 0);
    @(negedge clk); chk(irq == 0, "R8 nothing pending", irq, 0);
    wr(5'h0E, 8'h3F); wr(5'h0C, 8'hFF);

    // random transfers
    for (int k = 0; k < 8; k++) begin
      logic [31:0] sa;
      int nw;
      sa = 32'h0001_0000 | ((32'($urandom) % 4096) << 2);
      nw = 1 + int'($urandom % 50);
      run_xfer(sa, nw, 1'($urandom), 2'($urandom % 4), 8'(4 + $urandom % 28), 1'($urandom), st);
    end

    // R10 full, R6 halt, R11 flush: 16-beat bursts, locked, consumer stalled
    setup(32'h0000_3000, 64, 1, 2'd2, 8'd255, 1);
    cons_en = 0;
    wr(5'h01, 8'h01);
    repeat (150) @(negedge clk);
    rd(5'h0D, r); chk(r[1] == 1, "R10 full cause", r, 8'h02);
    chk(req_words == 32, "R4 room limits fetch", req_words, 32);
    wr(5'h02, 8'h01);
    chk_req = 0;
    begin
      bit quiet;
      quiet = 1;
      for (int c = 0; c < 30; c++) begin @(negedge clk); if (mem_req) quiet = 0; end
      chk(quiet, "R6 no request after halt", !quiet, 0);
    end
    rd(5'h0D, r); chk(r[2] == 0, "R6 no done after halt", r, 0);
    wr(5'h00, 8'h80 | 8'h0D);
    @(negedge clk); chk(smp_valid == 0, "R11 flush empties", smp_valid, 0);
    rd(5'h00, r); chk(r == 8'h0D, "R11 self clear", r, 8'h0D);

    // R4 zero threshold, R10 empty, R9 retry
    setup(32'h0000_4000, 8, 1, 2'd0, 8'd0, 0);
    cons_en = 1;
    wr(5'h01, 8'h01);
    repeat (20) @(negedge clk);
    chk(req_words == 0, "R4 zero threshold", req_words, 0);
    rd(5'h0D, r); chk(r[0] == 1, "R10 empty while running", r, 8'h01);
    wr(5'h01, 8'h01);
    rd(5'h0D, r); chk(r[3] == 1, "R9 retry cause", r, 8'h08);
    wr(5'h02, 8'h01);
    wr(5'h0D, 8'h3F);
    repeat (5) @(negedge clk);
    rd(5'h0D, r); chk(r[0] == 0, "R10 no empty when idle", r, 0);
    cons_en = 0;

    // R9 lost beat
    inject_lost = 1;
    repeat (4) @(negedge clk);
    rd(5'h0D, r); chk(r[4] == 1, "R9 lost cause", r, 8'h10);

    summary();
    $finish;
  end
endmodule